// File: doc/BRIEF.md
# Inter-processor interrupt command unit

This block sits beside one processor and turns software writes into inter-processor interrupt messages. Software first writes the destination word, then the command word; writing the command word is the launch. The unit checks the command, expands the destination (an explicit ID, a logical bit set, or a shorthand for self, everyone, or everyone but self) into a per-processor target mask and presents one message on a valid/ready port. While the message waits for acceptance, the delivery-status bit in the command word reads back as pending.

Faults from the sending side (bad vector, empty target set, checksum failure on acceptance) and from the receiving side (reported on a small fault input) collect in a sticky error status register. Any access to an undefined register offset also lands there. Software clears the error status register by writing it.

The launch controller is a two-state machine. State `ST_IDLE` waits for a command-word write. From it, transition `T_LAUNCH` (command legal and target set non-empty) goes to `ST_PEND`, and transition `T_REJECT` (illegal vector or empty target set) stays in `ST_IDLE` and raises an error. In `ST_PEND`, transition `T_HOLD` keeps the message valid while `msg_ready` is low, and transition `T_DONE` returns to `ST_IDLE` on the handshake.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset the command word, destination word and error status register all read 0, and `msg_valid` is 0.
- R2: The command word (offset 0) keeps vector in bits 7:0, delivery mode in 10:8, destination mode in 11 (0 physical, 1 logical), level in 14, trigger in 15 and shorthand in 19:18. All other bits read 0, except bit 12, which is the delivery status. The destination word (offset 1) keeps the 8-bit destination ID in bits 31:24, and its other bits read 0. The error status register is at offset 2.
- R3: A command-word write in idle that passes the checks raises `msg_valid` from the next cycle. The message carries vector, mode, level and trigger from that write and the destination word as it stood when the write was made.
- R4: Delivery status (command word bit 12) reads 1 from the cycle after launch until the cycle after the `msg_valid`/`msg_ready` handshake. While pending, the message fields do not change.
- R5: A command-word write while a message is pending is ignored: neither the stored command word nor the message changes.
- R6: Shorthand 00 uses the destination field, 01 targets only `self_id`, 10 targets all processors, and 11 targets all processors except `self_id`.
- R7: With shorthand 00 in physical mode, an ID below NCPU selects exactly that processor and ID 0xFF selects all of them. In logical mode, the low NCPU bits of the ID are the target mask.
- R8: Fixed mode (000) with a vector below 16 sets error bit 5 and emits no message.
- R9: A command whose target set is empty sets error bit 2 and emits no message.
- R10: A read or write of any offset other than 0, 1 or 2 sets error bit 7.
- R11: `rx_fault` bits 0, 1 and 2 set error bits 1, 3 and 6. `msg_cksum_err` high during the handshake sets error bit 0.
- R12: Error bits are sticky until the error status register is written, which clears them. A fault arriving in the same cycle as the clear write is kept.
- R13: For STARTUP mode (110), `msg_start_addr` equals the vector times 4096. For all other modes it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | 8 | ID of the owning processor |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational on reg_addr) |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Message accepted |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_level | output | 1 | Level assert bit |
| msg_trigger | output | 1 | Trigger mode bit |
| msg_dest_mask | output | NCPU | Expanded target mask |
| msg_start_addr | output | 20 | Start address for STARTUP messages |
| msg_cksum_err | input | 1 | Checksum fault reported with acceptance |
| rx_fault | input | 3 | Receive faults: checksum, accept, illegal vector |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a command-word write and a pending message: the bench writes a new command while the previous one still waits for `msg_ready`, then checks that the stored word and the message fields are unchanged. The second pair is the clear write to the error status register and a new fault: the bench pulses `rx_fault` in the same cycle as the clear write and checks that only the new fault's bit survives. The launch checks are driven from a vector table that covers every shorthand, both destination modes, out-of-range IDs and the illegal vector case. In each case the bench judges the target mask, the valid flag and the error register in the cycle after the write.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
    localparam int REG_AW = 4;
    localparam int ERR_W  = 8;

    localparam logic [REG_AW-1:0] OFS_CMD  = 4'd0;
    localparam logic [REG_AW-1:0] OFS_DEST = 4'd1;
    localparam logic [REG_AW-1:0] OFS_ERR  = 4'd2;

    localparam logic [2:0] MODE_FIXED   = 3'b000;
    localparam logic [2:0] MODE_STARTUP = 3'b110;

    localparam logic [1:0] SH_NONE     = 2'b00;
    localparam logic [1:0] SH_SELF     = 2'b01;
    localparam logic [1:0] SH_ALL      = 2'b10;
    localparam logic [1:0] SH_ALL_EXCL = 2'b11;

    localparam logic [31:0] CMD_KEEP  = 32'h000C_CFFF;
    localparam logic [7:0]  MIN_VECTOR = 8'd16;

    typedef enum logic {ST_IDLE, ST_PEND} launch_state_e;
endpackage

// File: rtl/ipi_dest_expand.sv
module ipi_dest_expand
    import ipi_cmd_pkg::*;
#(
    parameter int NCPU = 8
) (
    input  logic [1:0]      shorthand,
    input  logic            logical,
    input  logic [7:0]      dest_id,
    input  logic [7:0]      self_id,
    output logic [NCPU-1:0] mask
);
    logic [NCPU-1:0] phys_hit;
    logic [NCPU-1:0] log_hit;
    logic [NCPU-1:0] self_hit;

    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        assign phys_hit[g] = (dest_id == 8'(g)) || (dest_id == 8'hFF);
        assign self_hit[g] = (self_id == 8'(g));
        if (g < 8) begin : g_log
            assign log_hit[g] = dest_id[g];
        end else begin : g_nolog
            assign log_hit[g] = 1'b0;
        end
    end

    always_comb begin
        unique case (shorthand)
            SH_NONE:     mask = logical ? log_hit : phys_hit;
            SH_SELF:     mask = self_hit;
            SH_ALL:      mask = '1;
            SH_ALL_EXCL: mask = ~self_hit;
            default:     mask = '0;
        endcase
    end
endmodule

// File: rtl/ipi_launch_fsm.sv
module ipi_launch_fsm
    import ipi_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic bad_vector,
    input  logic empty_dest,
    input  logic msg_ready,
    output logic pending,
    output logic load_msg,
    output logic handshake,
    output logic err_illvec,
    output logic err_accept
);
    launch_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_wr && !bad_vector && !empty_dest) state_d = ST_PEND; // T_LAUNCH
            ST_PEND: if (msg_ready) state_d = ST_IDLE;                           // T_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending    = 1'b0;
        load_msg   = 1'b0;
        handshake  = 1'b0;
        err_illvec = 1'b0;
        err_accept = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wr) begin
                    err_illvec = bad_vector;                 // T_REJECT
                    err_accept = !bad_vector && empty_dest;  // T_REJECT
                    load_msg   = !bad_vector && !empty_dest; // T_LAUNCH
                end
            end
            ST_PEND: begin
                pending   = 1'b1;
                handshake = msg_ready;                       // T_DONE / T_HOLD
            end
            default: ;
        endcase
    end

    // R8: a rejected illegal vector never leaves idle
    p_no_emit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_wr && bad_vector) |=> (state_q == ST_IDLE));

    // R4: pending persists until acceptance
    p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && !msg_ready) |=> (state_q == ST_PEND));
endmodule

// File: rtl/ipi_err_status.sv
module ipi_err_status
    import ipi_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] set,
    input  logic             clr,
    output logic [ERR_W-1:0] q
);
    localparam logic [ERR_W-1:0] IMPL = 8'hEF;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((clr ? '0 : q) | set) & IMPL;
    end

    // R12: without a clear, no set bit is lost
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((q & $past(q)) == $past(q)));

    // R12: a fault arriving with the clear survives
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set[6]) |=> q[6]);
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
    import ipi_cmd_pkg::*;
#(
    parameter int NCPU = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        self_id,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_mode,
    output logic              msg_level,
    output logic              msg_trigger,
    output logic [NCPU-1:0]   msg_dest_mask,
    output logic [19:0]       msg_start_addr,
    input  logic              msg_cksum_err,
    input  logic [2:0]        rx_fault
);
    logic [31:0]      cmd_q;
    logic [7:0]       dest_q;
    logic [NCPU-1:0]  mask_d;
    logic             cmd_wr, pending, load_msg, handshake;
    logic             err_illvec, err_accept, bad_vector, bad_addr;
    logic [ERR_W-1:0] err_set, err_q;

    assign cmd_wr     = reg_wr && (reg_addr == OFS_CMD);
    assign bad_vector = (reg_wdata[10:8] == MODE_FIXED) && (reg_wdata[7:0] < MIN_VECTOR);
    assign bad_addr   = (reg_wr || reg_rd) && (reg_addr != OFS_CMD)
                        && (reg_addr != OFS_DEST) && (reg_addr != OFS_ERR);

    ipi_dest_expand #(.NCPU(NCPU)) u_expand (
        .shorthand (reg_wdata[19:18]),
        .logical   (reg_wdata[11]),
        .dest_id   (dest_q),
        .self_id   (self_id),
        .mask      (mask_d)
    );

    ipi_launch_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .bad_vector (bad_vector),
        .empty_dest (mask_d == '0),
        .msg_ready  (msg_ready),
        .pending    (pending),
        .load_msg   (load_msg),
        .handshake  (handshake),
        .err_illvec (err_illvec),
        .err_accept (err_accept)
    );

    assign err_set = {bad_addr, rx_fault[2], err_illvec, 1'b0,
                      rx_fault[1], err_accept, rx_fault[0], handshake && msg_cksum_err};

    ipi_err_status u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .clr   (reg_wr && (reg_addr == OFS_ERR)),
        .q     (err_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            dest_q <= '0;
        end else begin
            if (cmd_wr && !pending) cmd_q <= reg_wdata & CMD_KEEP;
            if (reg_wr && reg_addr == OFS_DEST) dest_q <= reg_wdata[31:24];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_vector    <= '0;
            msg_mode      <= '0;
            msg_level     <= 1'b0;
            msg_trigger   <= 1'b0;
            msg_dest_mask <= '0;
        end else if (load_msg) begin
            msg_vector    <= reg_wdata[7:0];
            msg_mode      <= reg_wdata[10:8];
            msg_level     <= reg_wdata[14];
            msg_trigger   <= reg_wdata[15];
            msg_dest_mask <= mask_d;
        end
    end

    assign msg_valid      = pending;
    assign msg_start_addr = (msg_mode == MODE_STARTUP) ? {msg_vector, 12'h000} : 20'h0;

    always_comb begin
        unique case (reg_addr)
            OFS_CMD:  reg_rdata = cmd_q | {19'b0, pending, 12'b0};
            OFS_DEST: reg_rdata = {dest_q, 24'b0};
            OFS_ERR:  reg_rdata = {24'b0, err_q};
            default:  reg_rdata = '0;
        endcase
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest_mask)));

    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && cmd_wr && !msg_ready) |=> ($stable(cmd_q) && $stable(msg_vector)));

    p_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_dest_mask != '0));

    p_phys_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid && cmd_wr && !bad_vector && reg_wdata[19:18] == SH_NONE
         && !reg_wdata[11] && 32'(dest_q) < NCPU) |=> (msg_valid && $onehot(msg_dest_mask)));
endmodule

// File: tb/tb_ipi_cmd_unit.sv
module tb_ipi_cmd_unit;
    localparam int NCPU = 8;
    localparam int NV   = 12;
    // {dest, cmd, mask, launch, err, start_addr}
    localparam logic [76:0] TBL [NV] = '{
        {8'h05, 32'h0000_0040, 8'h20, 1'b1, 8'h00, 20'h0},     // R7 physical
        {8'hFF, 32'h0000_0041, 8'hFF, 1'b1, 8'h00, 20'h0},     // R7 broadcast id
        {8'h96, 32'h0000_0850, 8'h96, 1'b1, 8'h00, 20'h0},     // R7 logical
        {8'h00, 32'h0004_0060, 8'h08, 1'b1, 8'h00, 20'h0},     // R6 self
        {8'h00, 32'h0008_0061, 8'hFF, 1'b1, 8'h00, 20'h0},     // R6 all
        {8'h00, 32'h000C_0062, 8'hF7, 1'b1, 8'h00, 20'h0},     // R6 all but self
        {8'h01, 32'h0000_000F, 8'h00, 1'b0, 8'h20, 20'h0},     // R8
        {8'h09, 32'h0000_0030, 8'h00, 1'b0, 8'h04, 20'h0},     // R9 id out of range
        {8'h02, 32'h0000_0402, 8'h04, 1'b1, 8'h00, 20'h0},     // R8 low vector ok outside fixed
        {8'h00, 32'h0000_0870, 8'h00, 1'b0, 8'h04, 20'h0},     // R9 logical empty
        {8'h01, 32'h0000_069A, 8'h02, 1'b1, 8'h00, 20'h9A000}, // R13
        {8'h07, 32'h0000_C0F0, 8'h80, 1'b1, 8'h00, 20'h0}      // R3 level/trigger
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0, msg_ready = 0, msg_cksum_err = 0;
    logic [3:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [2:0] rx_fault = 0;
    logic msg_valid, msg_level, msg_trigger;
    logic [7:0] msg_vector;
    logic [2:0] msg_mode;
    logic [NCPU-1:0] msg_dest_mask;
    logic [19:0] msg_start_addr;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ipi_cmd_unit #(.NCPU(NCPU)) dut (
        .clk(clk), .rst_n(rst_n), .self_id(8'd3),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_level(msg_level), .msg_trigger(msg_trigger),
        .msg_dest_mask(msg_dest_mask), .msg_start_addr(msg_start_addr),
        .msg_cksum_err(msg_cksum_err), .rx_fault(rx_fault)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic accept();
        @(negedge clk); msg_ready = 1;
        @(negedge clk); msg_ready = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(4'd0, v); chk(v == 0, "R1 cmd", v, 0);
        rd(4'd1, v); chk(v == 0, "R1 dest", v, 0);
        rd(4'd2, v); chk(v == 0, "R1 err", v, 0);
        chk(msg_valid == 0, "R1 valid", 32'(msg_valid), 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [7:0] e_dest, e_mask, e_err;
            logic [31:0] e_cmd;
            logic e_l;
            logic [19:0] e_addr;
            {e_dest, e_cmd, e_mask, e_l, e_err, e_addr} = TBL[i];
            wr(4'd2, 0);
            wr(4'd1, {e_dest, 24'h0});
            wr(4'd0, e_cmd);
            chk(msg_valid == e_l, "R3 launch", 32'(msg_valid), 32'(e_l));
            if (e_l) begin
                chk(msg_dest_mask == e_mask, "R6 R7 mask", 32'(msg_dest_mask), 32'(e_mask));
                chk(msg_vector == e_cmd[7:0] && msg_mode == e_cmd[10:8]
                    && msg_level == e_cmd[14] && msg_trigger == e_cmd[15], "R3 fields",
                    {16'h0, msg_trigger, msg_level, 3'b0, msg_mode, msg_vector}, e_cmd);
                chk(msg_start_addr == e_addr, "R13 start", 32'(msg_start_addr), 32'(e_addr));
            end
            rd(4'd2, v); chk(v == 32'(e_err), "R8 R9 err", v, 32'(e_err));
            if (e_l) accept();
        end

        // R2 layout, R4 status, R5 ignore
        wr(4'd1, 32'hAB12_3456);
        rd(4'd1, v); chk(v == 32'hAB00_0000, "R2 dest", v, 32'hAB00_0000);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v); chk(v == 32'h000C_DFFF, "R2 R4 pending", v, 32'h000C_DFFF);
        chk(msg_dest_mask == 8'hF7, "R6 excl", 32'(msg_dest_mask), 32'hF7);
        wr(4'd0, 32'h0000_0055);
        rd(4'd0, v); chk(v == 32'h000C_DFFF, "R5 cmd kept", v, 32'h000C_DFFF);
        chk(msg_vector == 8'hFF && msg_valid, "R5 msg kept", 32'(msg_vector), 32'hFF);
        repeat (3) @(negedge clk);
        chk(msg_valid == 1, "R4 hold", 32'(msg_valid), 1);
        @(negedge clk); msg_ready = 1; msg_cksum_err = 1;
        @(negedge clk); msg_ready = 0; msg_cksum_err = 0;
        #1 chk(msg_valid == 0, "R4 drop", 32'(msg_valid), 0);
        rd(4'd0, v); chk(v == 32'h000C_CFFF, "R4 idle", v, 32'h000C_CFFF);
        rd(4'd2, v); chk(v == 32'h01, "R11 cksum", v, 32'h01);

        // R10, R11, R12
        wr(4'd2, 0);
        rd(4'd5, v);
        rd(4'd2, v); chk(v == 32'h80, "R10 bad offset", v, 32'h80);
        wr(4'd9, 32'h1);
        rd(4'd1, v); chk(v == 32'hAB00_0000, "R10 no side effect", v, 32'hAB00_0000);
        wr(4'd2, 0);
        @(negedge clk); rx_fault = 3'b011;
        @(negedge clk); rx_fault = 0;
        repeat (4) @(negedge clk);
        rd(4'd2, v); chk(v == 32'h0A, "R11 R12 sticky", v, 32'h0A);
        @(negedge clk); reg_wr = 1; reg_addr = 4'd2; rx_fault = 3'b100;
        @(negedge clk); reg_wr = 0; rx_fault = 0;
        rd(4'd2, v); chk(v == 32'h40, "R12 clear with fault", v, 32'h40);
        wr(4'd2, 0);
        rd(4'd2, v); chk(v == 32'h00, "R12 cleared", v, 0);

        finish_run();
    end
endmodule